// File: doc/BRIEF.md
# 65xx Bus Glue Decoder

This block sits between a 65xx-style processor bus and asynchronous memories and peripherals. From a 16-bit address it produces active-low selects for a RAM region, a ROM region and an I/O page. It also produces one decoded select for a peripheral that lives in the top quarter of that page, plus a fixed-level output for the peripheral's spare select pin. The selects come from the address alone and are not gated by the clock. A device therefore wakes up while the address is still settling in the low half of the cycle, and is ready when its enable arrives.

The shared read strobe (output enable) and write strobe are the only outputs that depend on the phase-2 clock. Each strobe can be active only while phase 2 is high. A cycle starts at the fall of phase 2, and the address and R/W are guaranteed stable only in the high half. So a write can never be issued from a changing address or from a glitch on R/W, and every write is committed when the write strobe rises together with the fall of phase 2.

For checking, the block also gives a registered copy of the phase-2 level, taken on the system clock. A parameter selects this copy or a plain pass-through.

Top module: `glue_decoder`

## Requirements
- R1: `ram_cs_n` is low exactly for addresses 0x0000 to 0x7EFF and high for every other address.
- R2: `io_cs_n` is low exactly for addresses 0x7F00 to 0x7FFF. In that page it takes priority over RAM, so `ram_cs_n` stays high there.
- R3: `rom_cs_n` is low exactly for addresses 0x8000 to 0xFFFF. At most one of `ram_cs_n`, `rom_cs_n` and `io_cs_n` is low at any time.
- R4: `per_cs_n` is low exactly when the I/O page is addressed and address bits 7 and 6 are both 1 (0x7FC0 to 0x7FFF). `per_tie` is held at constant 1, the level that keeps the peripheral's spare select active.
- R5: All select outputs depend only on the address. For a given address they are the same for both levels of `phi2` and both levels of `rw`.
- R6: While `phi2` is 0, both `oe_n` and `we_n` are 1, whatever the value of `rw` or the address.
- R7: `we_n` is 0 exactly when `rw` is 0 (0 = write) and `phi2` is 1. This includes the ROM range, where `ram_cs_n` stays high while `we_n` is low.
- R8: `oe_n` is 0 exactly when `rw` is 1 (1 = read), `phi2` is 1 and the address selects RAM, ROM or the I/O page. `oe_n` and `we_n` are never both 0.
- R9: With the default registered variant, `phase_q` is 0 while `rst_n` is 0. After reset it equals the `phi2` value sampled at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the registered phase view |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | Bus direction, 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 bus clock level |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 1 | I/O page select, active low |
| per_cs_n | output | 1 | Decoded peripheral select inside the I/O page, active low |
| per_tie | output | 1 | Fixed level for the peripheral's unused select pin |
| oe_n | output | 1 | Shared output enable, active low |
| we_n | output | 1 | Shared write enable, active low |
| phase_q | output | 1 | Registered (or passed-through) view of `phi2` |

## Verification
In the same cycle, an address can assert a chip select while a strobe is still held off by phase 2. The block must never merge these two paths. The bench provokes this by sweeping every address with both R/W levels in both phase-2 halves. It judges the selects against an independent range decode that must not change with phase 2, and the strobes against the phase-2 gating rule. Separate scenarios toggle R/W during phase 2 low, and issue writes into ROM space, where the write strobe fires while the RAM select stays inactive.

// File: rtl/glue_pkg.sv
package glue_pkg;

   // internal, active-high view of the top-level selects
   typedef struct packed {
      logic ram;
      logic rom;
      logic io;
      logic per;
   } sel_t;

endpackage

// File: rtl/glue_addr_dec.sv
module glue_addr_dec
   import glue_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                PAGE_W    = 8,
   parameter logic [ADDR_W-1:0] RAM_LO    = 16'h0000,
   parameter logic [ADDR_W-1:0] RAM_HI    = 16'h7FFF,
   parameter logic [ADDR_W-1:0] ROM_LO    = 16'h8000,
   parameter logic [ADDR_W-1:0] ROM_HI    = 16'hFFFF,
   parameter int                IO_PAGE   = 'h7F,
   parameter int                PER_BITS  = 2,
   parameter int                PER_MATCH = 'b11
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              sel
);

   localparam int                      PG_FIELD_W = ADDR_W - PAGE_W;
   localparam logic [ADDR_W-1:0]       RAM_SPAN   = RAM_HI - RAM_LO;
   localparam logic [ADDR_W-1:0]       ROM_SPAN   = ROM_HI - ROM_LO;
   localparam logic [PG_FIELD_W-1:0]   IO_KEY     = PG_FIELD_W'(IO_PAGE);
   localparam logic [PER_BITS-1:0]     PER_KEY    = PER_BITS'(PER_MATCH);

   initial begin : elab_chk
      assert (PAGE_W > 0 && PAGE_W < ADDR_W)
         else $error("glue_addr_dec: PAGE_W out of range");
      assert (PER_BITS > 0 && PER_BITS <= PAGE_W)
         else $error("glue_addr_dec: PER_BITS wider than a page");
      assert (RAM_HI >= RAM_LO && ROM_HI >= ROM_LO)
         else $error("glue_addr_dec: inverted region bounds");
   end

   logic [ADDR_W-1:0] ram_off, rom_off;
   logic              io_hit, ram_hit, rom_hit, per_hit;

   // offset-and-span compare: one subtract and one compare per region
   assign ram_off = addr - RAM_LO;
   assign rom_off = addr - ROM_LO;

   assign io_hit  = (addr[ADDR_W-1:PAGE_W] == IO_KEY);
   assign ram_hit = (ram_off <= RAM_SPAN) && !io_hit;   // page wins over RAM
   assign rom_hit = (rom_off <= ROM_SPAN) && !io_hit;
   assign per_hit = io_hit && (addr[PAGE_W-1 -: PER_BITS] == PER_KEY);

   always_comb begin
      sel.ram = ram_hit;
      sel.rom = rom_hit;
      sel.io  = io_hit;
      sel.per = per_hit;
   end

endmodule

// File: rtl/glue_strobe.sv
module glue_strobe (
   input  logic phi2,
   input  logic rw,
   input  logic readable,
   output logic oe_n,
   output logic we_n
);

   logic rd_req, wr_req;

   // strobes open only in the high half of the bus cycle
   assign rd_req = phi2 &&  rw && readable;
   assign wr_req = phi2 && !rw;

   assign oe_n = !rd_req;
   assign we_n = !wr_req;

endmodule

// File: rtl/glue_phase_view.sv
module glue_phase_view #(
   parameter bit REG_PHASE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phi2,
   output logic phase_q
);

   generate
      if (REG_PHASE) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= phi2;
         end
         assign phase_q = q;
      end else begin : g_wire
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign phase_q   = phi2 | (unused_ok & 1'b0);
      end
   endgenerate

endmodule

// File: rtl/glue_decoder.sv
module glue_decoder
   import glue_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                PAGE_W        = 8,
   parameter logic [ADDR_W-1:0] RAM_LO        = 16'h0000,
   parameter logic [ADDR_W-1:0] RAM_HI        = 16'h7FFF,
   parameter logic [ADDR_W-1:0] ROM_LO        = 16'h8000,
   parameter logic [ADDR_W-1:0] ROM_HI        = 16'hFFFF,
   parameter int                IO_PAGE       = 'h7F,
   parameter int                PER_BITS      = 2,
   parameter int                PER_MATCH     = 'b11,
   parameter bit                PER_TIE_LEVEL = 1'b1,
   parameter bit                REG_PHASE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw,
   input  logic              phi2,
   output logic              ram_cs_n,
   output logic              rom_cs_n,
   output logic              io_cs_n,
   output logic              per_cs_n,
   output logic              per_tie,
   output logic              oe_n,
   output logic              we_n,
   output logic              phase_q
);

   sel_t sel;
   logic readable;

   glue_addr_dec #(
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W),
      .RAM_LO   (RAM_LO),
      .RAM_HI   (RAM_HI),
      .ROM_LO   (ROM_LO),
      .ROM_HI   (ROM_HI),
      .IO_PAGE  (IO_PAGE),
      .PER_BITS (PER_BITS),
      .PER_MATCH(PER_MATCH)
   ) u_dec (
      .addr(addr),
      .sel (sel)
   );

   // selects are never gated by phi2 so devices wake early
   assign ram_cs_n = !sel.ram;
   assign rom_cs_n = !sel.rom;
   assign io_cs_n  = !sel.io;
   assign per_cs_n = !sel.per;
   assign per_tie  = PER_TIE_LEVEL;

   assign readable = sel.ram || sel.rom || sel.io;

   glue_strobe u_stb (
      .phi2    (phi2),
      .rw      (rw),
      .readable(readable),
      .oe_n    (oe_n),
      .we_n    (we_n)
   );

   glue_phase_view #(
      .REG_PHASE(REG_PHASE)
   ) u_phv (
      .clk    (clk),
      .rst_n  (rst_n),
      .phi2   (phi2),
      .phase_q(phase_q)
   );

endmodule

// File: rtl/glue_decoder_chk.sv
module glue_decoder_chk #(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] ROM_LO = 16'h8000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rw,
   input logic              phi2,
   input logic              ram_cs_n,
   input logic              rom_cs_n,
   input logic              io_cs_n,
   input logic              per_cs_n,
   input logic              oe_n,
   input logic              we_n
);

   AST_RAM_BELOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> (addr < ROM_LO));                                    // R1

   AST_IO_OVER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cs_n |-> ram_cs_n);                                            // R2

   AST_ONE_TOP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!ram_cs_n, !rom_cs_n, !io_cs_n}));                       // R3

   AST_PER_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      !per_cs_n |-> !io_cs_n);                                           // R4

   AST_SEL_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(addr) |-> $stable({ram_cs_n, rom_cs_n, io_cs_n, per_cs_n})); // R5

   AST_NO_STROBE_PHI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |-> (oe_n && we_n));                                         // R6

   AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!rw && phi2));                                          // R7

   AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (rw && phi2));                                           // R8

   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n || we_n);                                                     // R8

endmodule

bind glue_decoder glue_decoder_chk #(
   .ADDR_W(ADDR_W),
   .ROM_LO(ROM_LO)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .rw      (rw),
   .phi2    (phi2),
   .ram_cs_n(ram_cs_n),
   .rom_cs_n(rom_cs_n),
   .io_cs_n (io_cs_n),
   .per_cs_n(per_cs_n),
   .oe_n    (oe_n),
   .we_n    (we_n)
);

// File: tb/tb_glue_decoder.sv
`timescale 1ns/100ps
module tb_glue_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        rw = 1'b1;
   logic        phi2 = 1'b0;
   logic        ram_cs_n, rom_cs_n, io_cs_n, per_cs_n, per_tie;
   logic        oe_n, we_n, phase_q;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   glue_decoder dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
      .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
      .per_cs_n(per_cs_n), .per_tie(per_tie),
      .oe_n(oe_n), .we_n(we_n), .phase_q(phase_q)
   );

   // reference map: {ram, rom, io, per}, active high
   function automatic logic [3:0] ref_sel(input logic [15:0] a);
      logic io, per, ram, rom;
      io  = (a[15:8] == 8'h7F);
      per = io && (a[7:6] == 2'b11);
      ram = (a <= 16'h7FFF) && !io;
      rom = (a >= 16'h8000);
      return {ram, rom, io, per};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s addr=%h rw=%0b phi2=%0b actual=%0h expected=%0h",
                  tag, addr, rw, phi2, act, exp);
      end
   endtask

   function automatic logic [3:0] got_sel();
      return ~{ram_cs_n, rom_cs_n, io_cs_n, per_cs_n};
   endfunction

   task automatic apply(input logic [15:0] a, input logic r, input logic p);
      addr = a; rw = r; phi2 = p;
      #1;
   endtask

   task automatic check_point(input string tag);
      logic [3:0] e;
      logic       e_we_n, e_oe_n;
      e      = ref_sel(addr);
      e_we_n = !(!rw && phi2);
      e_oe_n = !(rw && phi2 && (e[3] || e[2] || e[1]));
      check(got_sel() == e, {tag, " selects R1 R2 R3 R4 R5"}, got_sel(), e);
      check({oe_n, we_n} == {e_oe_n, e_we_n}, {tag, " strobes R6 R7 R8"},
            {oe_n, we_n}, {e_oe_n, e_we_n});
   endtask

   task automatic t_reset();
      phi2 = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(phase_q == 1'b0, "reset phase_q R9", phase_q, 0);
      check(per_tie == 1'b1, "tie level R4", per_tie, 1);
      @(negedge clk);
      phi2 = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_boundaries();
      logic [15:0] pts [8] = '{16'h0000, 16'h7EFF, 16'h7F00, 16'h7FBF,
                               16'h7FC0, 16'h7FFF, 16'h8000, 16'hFFFF};
      foreach (pts[i]) begin
         for (int r = 0; r < 2; r++) begin
            apply(pts[i], r[0], 1'b1);
            check_point("boundary");
         end
      end
      apply(16'h7EFF, 1'b1, 1'b1);
      check(!ram_cs_n && io_cs_n, "7EFF is RAM R1", {ram_cs_n, io_cs_n}, 2'b01);
      apply(16'h7F00, 1'b1, 1'b1);
      check(ram_cs_n && !io_cs_n && per_cs_n, "7F00 page not RAM R2",
            {ram_cs_n, io_cs_n, per_cs_n}, 3'b101);
      apply(16'h7FC0, 1'b1, 1'b1);
      check(!per_cs_n, "7FC0 peripheral R4", per_cs_n, 0);
      apply(16'h8000, 1'b1, 1'b1);
      check(!rom_cs_n && ram_cs_n, "8000 is ROM R3", {rom_cs_n, ram_cs_n}, 2'b01);
   endtask

   task automatic t_rw_glitch_low_phase();
      for (int k = 0; k < 16; k++) begin
         apply(16'h1234 + 16'(k * 4099), k[0], 1'b0);
         check(oe_n && we_n, "rw toggles in phi2 low R6", {oe_n, we_n}, 2'b11);
      end
   endtask

   task automatic t_rom_write();
      apply(16'hC000, 1'b0, 1'b1);
      check(!we_n && ram_cs_n, "ROM write: we low, ram select off R7",
            {we_n, ram_cs_n}, 2'b01);
      apply(16'hC000, 1'b0, 1'b0);
      check(we_n, "ROM write closes at phi2 fall R7", we_n, 1);
   endtask

   task automatic t_sweep();
      logic [3:0] s_lo;
      for (int a = 0; a < 65536; a++) begin
         for (int r = 0; r < 2; r++) begin
            apply(16'(a), r[0], 1'b0);
            check_point("sweep lo");
            s_lo = got_sel();
            apply(16'(a), r[0], 1'b1);
            check_point("sweep hi");
            if (got_sel() != s_lo)
               check(1'b0, "phase independence R5", got_sel(), s_lo);
         end
      end
   endtask

   task automatic t_phase_view();
      @(negedge clk);
      phi2 = 1'b1;
      @(posedge clk); #1;
      check(phase_q == 1'b1, "phase view follows high R9", phase_q, 1);
      @(negedge clk);
      phi2 = 1'b0; #1;
      check(phase_q == 1'b1, "phase view holds until edge R9", phase_q, 1);
      @(posedge clk); #1;
      check(phase_q == 1'b0, "phase view follows low R9", phase_q, 0);
   endtask

   initial begin
      t_reset();
      t_boundaries();
      t_rw_glitch_low_phase();
      t_rom_write();
      t_phase_view();
      t_sweep();
      t_phase_view();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule